// File: doc/BRIEF.md
# Backplane Source Selector and Divider

This block produces the common backplane square wave for a static LCD segment driver. It has two possible sources. One is a local oscillator pulse train, which it divides by sixteen. The other is a backplane signal from an upstream driver, which it regenerates. It makes no choice while reset is held. After release it watches the oscillator input. The first rising edge it sees commits the block to the divided oscillator, and that choice holds until the next reset. If the oscillator input never rises, for example because it is tied low on a downstream driver, the output follows the incoming backplane.

In a chain of drivers, only the head device runs an oscillator. Its output is looped back to its own backplane input, and the devices after it regenerate the backplane from their backplane input. Every segment output in the chain therefore toggles against one common square wave. Both inputs are sampled through synchronizer stages into the system clock domain. The output is a registered signal and is held low during reset.

Top module: `bp_source_sel`

## Requirements
- R1: While `rst_n` is low, `bpl_out` is low, whatever `osc_in` and `bpl_in` do.
- R2: After reset release, if no rising edge of `osc_in` has been seen, `bpl_out` equals `bpl_in` delayed by SYNC_STAGES+1 clock cycles (3 cycles with defaults).
- R3: The first rising edge of the synchronized `osc_in` after reset release selects the internal source. The selection is sticky and is only cleared by reset.
- R4: In internal mode, a DIV_LOG2-bit counter (4 bits by default) advances by one on each synchronized `osc_in` rising edge. It counts from zero, and the first edge that selects the mode also counts. `bpl_out` is the counter's most significant bit. After the k-th edge since reset, `bpl_out` is 1 exactly when (k mod 16) is 8 or more. This gives a divide-by-16 output with 50% duty cycle.
- R5: Once the internal source is selected, changes on `bpl_in` have no effect on `bpl_out`. Without an oscillator edge, `bpl_out` holds its value.
- R6: A new reset clears both the selection and the counter. After it, the block again follows `bpl_in` until an oscillator edge arrives, and it counts edges from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples both backplane sources |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_in | input | 1 | Oscillator pulse input, tied low when the local oscillator is unused |
| bpl_in | input | 1 | Incoming backplane signal from upstream, or the looped-back own output |
| bpl_out | output | 1 | Regenerated or divided backplane square wave |

## Verification
The assertions check, on every cycle, that the output is low in reset and that the source selection never falls back once set. They also check that the counter moves only by single increments while the internal source is selected, and that the output holds whenever the counter holds in that mode. Some properties depend on the number of oscillator edges since reset or on the tracking latency in external mode. These are the exact divide-by-16 phase, the delayed follow of the backplane input, and the clean restart after a second reset. Only the bench scenarios can show them.

// File: rtl/bp_pkg.sv
package bp_pkg;

    // Which source drives the backplane output
    typedef enum logic {
        SRC_EXT = 1'b0,
        SRC_INT = 1'b1
    } bp_src_e;

endpackage

// File: rtl/bp_sync.sv
// Multi-stage synchronizer for a vector of asynchronous inputs.
module bp_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    typedef struct packed {
        logic [STAGES-1:0][WIDTH-1:0] pipe;
    } sync_state_t;

    sync_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.pipe[0] = d;
        for (int i = 1; i < STAGES; i++) begin
            st_d.pipe[i] = st_q.pipe[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign q = st_q.pipe[STAGES-1];

endmodule

// File: rtl/bp_osc_div.sv
// Detects rising edges of the synchronized oscillator, latches the source
// selection on the first one, and counts edges for the divider.
module bp_osc_div
    import bp_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             osc_s,
    output bp_src_e          src,
    output logic [CNT_W-1:0] cnt,
    output bp_src_e          src_next,
    output logic [CNT_W-1:0] cnt_next
);

    typedef struct packed {
        logic             osc_prev;
        bp_src_e          src;
        logic [CNT_W-1:0] cnt;
    } div_state_t;

    div_state_t st_d, st_q;
    logic       osc_rise;

    always_comb begin
        st_d          = st_q;
        osc_rise      = osc_s & ~st_q.osc_prev;
        st_d.osc_prev = osc_s;
        if (osc_rise) begin
            st_d.src = SRC_INT;
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{osc_prev: 1'b0, src: SRC_EXT, cnt: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign src      = st_q.src;
    assign cnt      = st_q.cnt;
    assign src_next = st_d.src;
    assign cnt_next = st_d.cnt;

endmodule

// File: rtl/bp_source_sel.sv
module bp_source_sel
    import bp_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int DIV_LOG2    = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic osc_in,
    input  logic bpl_in,
    output logic bpl_out
);

    localparam int SYNC_W = 2;
    localparam int MSB    = DIV_LOG2 - 1;

    logic [SYNC_W-1:0]   raw_in, sync_out;
    logic                osc_s, bpl_s;
    bp_src_e             src_q, src_d;
    logic [DIV_LOG2-1:0] div_cnt, cnt_d;
    logic                sel_int;

    typedef struct packed {
        logic out;
    } out_state_t;

    out_state_t st_d, st_q;

    assign raw_in = {bpl_in, osc_in};

    bp_sync #(
        .WIDTH (SYNC_W),
        .STAGES(SYNC_STAGES)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (raw_in),
        .q    (sync_out)
    );

    assign osc_s = sync_out[0];
    assign bpl_s = sync_out[1];

    bp_osc_div #(
        .CNT_W(DIV_LOG2)
    ) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .osc_s   (osc_s),
        .src     (src_q),
        .cnt     (div_cnt),
        .src_next(src_d),
        .cnt_next(cnt_d)
    );

    assign sel_int = (src_q == SRC_INT);

    always_comb begin
        st_d = st_q;
        if (src_d == SRC_INT) begin
            st_d.out = cnt_d[MSB];
        end else begin
            st_d.out = bpl_s;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bpl_out = st_q.out;

endmodule

// File: rtl/bp_source_sel_chk.sv
module bp_source_sel_chk #(
    parameter int CNT_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bpl_out,
    input logic             sel_int,
    input logic [CNT_W-1:0] div_cnt
);

    always @(posedge clk) begin
        if (!rst_n) begin
            AST_RESET_LOW: assert (!bpl_out); // R1
        end
    end

    AST_SEL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        sel_int |=> sel_int); // R3

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (div_cnt != $past(div_cnt)) |-> (div_cnt == CNT_W'($past(div_cnt) + 1'b1))); // R4

    AST_CNT_NEEDS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        (div_cnt != $past(div_cnt)) |-> sel_int); // R3

    AST_INT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_int && $past(sel_int) && $stable(div_cnt)) |-> $stable(bpl_out)); // R5

endmodule

bind bp_source_sel bp_source_sel_chk #(
    .CNT_W(DIV_LOG2)
) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .bpl_out(bpl_out),
    .sel_int(sel_int),
    .div_cnt(div_cnt)
);

// File: tb/bp_source_sel_test.sv
module bp_source_sel_test;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic osc_in = 1'b0;
    logic bpl_in = 1'b0;
    logic bpl_out;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    bp_source_sel uut (
        .clk    (clk),
        .rst_n  (rst_n),
        .osc_in (osc_in),
        .bpl_in (bpl_in),
        .bpl_out(bpl_out)
    );

    task automatic check(input string req, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: bpl_out=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        osc_in = 1'b0;
        wait_cyc(3);
        rst_n = 1'b1;
        wait_cyc(2);
    endtask

    // one oscillator period, long enough for the synchronizer
    task automatic osc_pulse();
        osc_in = 1'b1;
        wait_cyc(6);
        osc_in = 1'b0;
        wait_cyc(6);
    endtask

    task automatic t_reset_low();
        @(negedge clk);
        rst_n = 1'b0;
        bpl_in = 1'b1;
        for (int i = 0; i < 8; i++) begin
            osc_in = ~osc_in;
            wait_cyc(2);
            check("R1", bpl_out, 1'b0);
        end
        osc_in = 1'b0;
        bpl_in = 1'b0;
        rst_n = 1'b1;
        wait_cyc(2);
    endtask

    task automatic t_external(input string req);
        for (int i = 0; i < 6; i++) begin
            bpl_in = ~bpl_in;
            wait_cyc(2);
            check(req, bpl_out, ~bpl_in); // not yet through 3-cycle path
            wait_cyc(2);
            check(req, bpl_out, bpl_in);
        end
        bpl_in = 1'b1;
        wait_cyc(5);
        check(req, bpl_out, 1'b1);
        bpl_in = 1'b0;
        wait_cyc(5);
        check(req, bpl_out, 1'b0);
    endtask

    task automatic t_internal(input string req, input int pulses);
        bpl_in = 1'b0;
        for (int k = 1; k <= pulses; k++) begin
            osc_pulse();
            check(req, bpl_out, ((k % 16) >= 8));
        end
    endtask

    task automatic t_sticky();
        logic held;
        held = bpl_out;
        for (int i = 0; i < 6; i++) begin
            bpl_in = ~bpl_in;
            wait_cyc(5);
            check("R5", bpl_out, held);
        end
        bpl_in = ~held;
        wait_cyc(10);
        check("R3", bpl_out, held);
    endtask

    task automatic t_rereset();
        do_reset();
        check("R6", bpl_out, 1'b0);
        t_external("R6");
        t_internal("R6", 20);
    endtask

    initial begin
        wait_cyc(4);
        rst_n = 1'b1;
        wait_cyc(2);
        check("R1", bpl_out, 1'b0);
        t_reset_low();
        do_reset();
        t_external("R2");
        do_reset();
        t_internal("R4", 40); // ends at count 40: output high
        t_sticky();
        t_rereset();
        if (!done) begin
            done = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

endmodule